// File: doc/BRIEF.md
# Half-Unit-Biased Floating-Point Adder

This block adds or subtracts two floating-point operands held in the half-unit-biased (HUB) format and returns the packed result. A HUB significand has a leading one that is not stored, the explicit mantissa bits, and a trailing one that is also not stored. Because of that trailing one, each bit pattern sits exactly halfway between two neighbouring conventional values. As a result, cutting the exact sum down to the explicit width already gives round-to-nearest. The datapath therefore has no guard bits, no sticky bit and no rounding incrementer.

The exponent width and the mantissa width are parameters. The operation runs through a two-stage pipeline. The first stage orders the operands by magnitude and aligns the smaller one. The second stage adds or subtracts, normalises and packs the result. An operand is accepted whenever `in_valid` is high, and the block can take a new operand pair on every clock cycle. Subnormals, infinities, NaNs and exception flags are not supported. An exponent field of zero is the encoding for zero. A result that is too large saturates, and a result that is too small flushes to zero.

Top module: `hub_fp_adder`

## Requirements
- R1: A word is {sign at the MSB, EXP_W-bit exponent e, MAN_W-bit mantissa m}. For e != 0 its value is (-1)^sign * 2^e * (1 + m/2^MAN_W + 2^-(MAN_W+1)), up to a constant scale. The result is the word whose exponent and mantissa are the leading-one position and the next MAN_W bits of the exact sum, with every lower bit dropped.
- R2: Operands sampled at rising edge n with `in_valid` high produce `out_valid` high and the result after edge n+1. `out_valid` is `in_valid` delayed by two edges, so back-to-back inputs give back-to-back outputs.
- R3: The sign of a non-zero result is the sign of the operand with the larger magnitude. Two non-zero operands with the same effective sign give a result of that sign.
- R4: With `op_sub` high the block computes opa - opb, which is opa plus opb with its sign inverted.
- R5: An operand whose exponent field is zero is zero, and its sign and mantissa bits are ignored. If exactly one operand is zero, the result is the other word unchanged, with its sign inverted when it is opb and `op_sub` is high. If both are zero, the result is the all-zero word.
- R6: When the exact sum is zero (equal magnitudes cancelling), the result is the all-zero word.
- R7: When the normalised exponent exceeds 2^EXP_W - 1, the result saturates to the sign, an all-ones exponent and an all-ones mantissa.
- R8: When the normalised exponent is 0 or below, the result is the all-zero word.
- R9: When the exponents differ by MAN_W+2 or more, the result equals the larger operand with its effective sign.
- R10: A clock edge with `rst_n` low clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| op_sub | input | 1 | 1 = subtract opb from opa |
| opa | input | 1+EXP_W+MAN_W | First operand, packed HUB word |
| opb | input | 1+EXP_W+MAN_W | Second operand, packed HUB word |
| out_valid | output | 1 | Result present |
| result | output | 1+EXP_W+MAN_W | Packed HUB result |

## Verification
The bench computes the exact sum of the two operands as a wide integer, including both implicit trailing ones, and truncates it to build the expected word. A design that dropped the trailing one, or that rounded instead of truncating, would then be off by one unit in the last place on many random pairs. Directed cases cover cancellation near unity, cancellation to exactly zero, exponent overflow, and exponent differences of MAN_W+1 and MAN_W+2. These catch a faulty far-shift cutoff, a missing flush to zero, or a wrapped exponent where saturation is required. Zero operands with non-zero sign and mantissa bits, given to both inputs with and without subtraction, catch a design that reads those ignored bits or forgets to invert the sign of opb.

// File: rtl/hub_fp_pkg.sv
// Shared definitions for the HUB floating-point adder.
// Assumes: nothing beyond the enum below is shared between stages.
package hub_fp_pkg;
    // Which of the result-forming paths stage 2 must take
    typedef enum logic [1:0] {
        PATH_ARITH = 2'd0,   // both operands non-zero: add or subtract
        PATH_PASS  = 2'd1,   // exactly one operand zero: forward the other
        PATH_ZERO  = 2'd2    // both operands zero
    } hub_path_e;
endpackage

// File: rtl/hub_fp_align.sv
// Stage-1 logic: orders the operands by magnitude, builds the significands
// with hidden leading one and implicit trailing one, and right-shifts the
// smaller one. Assumes exponent field zero encodes zero. Shifts of MAN_W+2
// or more clear the smaller operand, since it can no longer change a
// truncated result.
module hub_fp_align
    import hub_fp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                     op_sub,
    input  logic [EXP_W+MAN_W:0]     opa,
    input  logic [EXP_W+MAN_W:0]     opb,
    output hub_path_e                path,
    output logic                     res_sign,
    output logic                     eff_sub,
    output logic [EXP_W-1:0]         big_exp,
    output logic [MAN_W+1:0]         big_sig,
    output logic [2*MAN_W+2:0]       small_al,
    output logic [EXP_W+MAN_W:0]     pass_word
);
    localparam int W    = 1 + EXP_W + MAN_W;
    localparam int AL_W = 2 * MAN_W + 3;
    localparam int SH_W = $clog2(MAN_W + 3);

    logic             sa, sb_eff, a_zero, b_zero, swap, far;
    logic [EXP_W-1:0] ea, eb, es, diff;
    logic [MAN_W-1:0] ma, mb, mbig, msmall;
    logic [31:0]      diff32;
    logic [AL_W-1:0]  small_ext;

    // Field extraction and effective sign of the second operand
    always_comb begin
        sa     = opa[W-1];
        ea     = opa[W-2 -: EXP_W];
        ma     = opa[MAN_W-1:0];
        sb_eff = opb[W-1] ^ op_sub;
        eb     = opb[W-2 -: EXP_W];
        mb     = opb[MAN_W-1:0];
        a_zero = (ea == '0);
        b_zero = (eb == '0);
        swap   = ({eb, mb} > {ea, ma});
    end

    // Select larger/smaller operand and align the smaller one
    always_comb begin
        big_exp   = swap ? eb : ea;
        mbig      = swap ? mb : ma;
        es        = swap ? ea : eb;
        msmall    = swap ? ma : mb;
        res_sign  = swap ? sb_eff : sa;
        eff_sub   = sa ^ sb_eff;
        diff      = big_exp - es;
        diff32    = 32'(diff);
        far       = (diff32 >= 32'(MAN_W + 2));
        big_sig   = {1'b1, mbig, 1'b1};
        small_ext = {1'b1, msmall, 1'b1, {(MAN_W + 1){1'b0}}};
        small_al  = far ? '0 : (small_ext >> diff32[SH_W-1:0]);
    end

    // Zero-operand routing
    always_comb begin
        if (a_zero && b_zero) begin
            path      = PATH_ZERO;
            pass_word = '0;
        end else if (a_zero) begin
            path      = PATH_PASS;
            pass_word = {sb_eff, eb, mb};
        end else if (b_zero) begin
            path      = PATH_PASS;
            pass_word = opa;
        end else begin
            path      = PATH_ARITH;
            pass_word = '0;
        end
    end
endmodule

// File: rtl/hub_fp_lzd.sv
// Leading-one detector: reports the index of the highest set bit.
// Assumes: the caller handles the all-zero input separately (pos is 0 then).
module hub_fp_lzd #(
    parameter int IN_W = 50
) (
    input  logic [IN_W-1:0]         vec,
    output logic [$clog2(IN_W)-1:0] pos
);
    localparam int POS_W = $clog2(IN_W);

    // Scan upward; the highest set bit wins
    always_comb begin
        pos = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (vec[i]) pos = POS_W'(i);
        end
    end
endmodule

// File: rtl/hub_fp_norm.sv
// Stage-2 logic: adds or subtracts the aligned significands exactly,
// normalises on the leading one, keeps MAN_W bits below it (truncation is
// the rounding), and applies saturation and flush-to-zero to the exponent.
// Assumes the larger-magnitude operand arrives as big_sig, so the
// difference is never negative.
module hub_fp_norm
    import hub_fp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  hub_path_e                path,
    input  logic                     res_sign,
    input  logic                     eff_sub,
    input  logic [EXP_W-1:0]         big_exp,
    input  logic [MAN_W+1:0]         big_sig,
    input  logic [2*MAN_W+2:0]       small_al,
    input  logic [EXP_W+MAN_W:0]     pass_word,
    output logic [EXP_W+MAN_W:0]     word
);
    localparam int SUM_W   = 2 * MAN_W + 4;
    localparam int POS_W   = $clog2(SUM_W);
    localparam int XW      = EXP_W + POS_W + 2;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    logic [SUM_W-1:0] big_ext, small_ext, sum;
    logic [POS_W-1:0] lead, sh;
    logic [MAN_W:0]   top_bits;
    logic [XW-1:0]    e_adj;
    logic             nonzero, under, over;

    // Exact add/subtract of the aligned significands
    always_comb begin
        big_ext   = {1'b0, big_sig, {(MAN_W + 1){1'b0}}};
        small_ext = {1'b0, small_al};
        sum       = eff_sub ? (big_ext - small_ext) : (big_ext + small_ext);
    end

    hub_fp_lzd #(.IN_W(SUM_W)) u_lzd (
        .vec (sum),
        .pos (lead)
    );

    // Normalise, truncate, and adjust the exponent
    always_comb begin
        sh       = POS_W'(SUM_W - 1) - lead;
        top_bits = (MAN_W + 1)'((sum << sh) >> (SUM_W - 1 - MAN_W));
        nonzero  = top_bits[MAN_W];
        e_adj    = XW'(big_exp) + XW'(lead) - XW'(SUM_W - 2);
        under    = e_adj[XW-1] || (e_adj == '0);
        over     = !e_adj[XW-1] && (e_adj > XW'(EXP_MAX));
    end

    // Pick the output word for the path in use
    always_comb begin
        unique case (path)
            PATH_ZERO: word = '0;
            PATH_PASS: word = pass_word;
            default: begin
                if (!nonzero || under)
                    word = '0;
                else if (over)
                    word = {res_sign, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
                else
                    word = {res_sign, e_adj[EXP_W-1:0], top_bits[MAN_W-1:0]};
            end
        endcase
    end
endmodule

// File: rtl/hub_fp_adder.sv
// Top of the HUB floating-point adder/subtractor. Two register stages:
// alignment results, then the packed sum. Latency is two edges and a new
// pair may enter every cycle. Assumes a synchronous active-low reset.
module hub_fp_adder
    import hub_fp_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 op_sub,
    input  logic [EXP_W+MAN_W:0] opa,
    input  logic [EXP_W+MAN_W:0] opb,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] result
);
    localparam int W    = 1 + EXP_W + MAN_W;
    localparam int AL_W = 2 * MAN_W + 3;

    hub_path_e        a_path, s1_path;
    logic             a_sign, a_sub, s1_sign, s1_sub, s1_valid;
    logic [EXP_W-1:0] a_exp, s1_exp;
    logic [MAN_W+1:0] a_sig, s1_sig;
    logic [AL_W-1:0]  a_small, s1_small;
    logic [W-1:0]     a_pass, s1_pass, n_word;

    hub_fp_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
        .op_sub    (op_sub),
        .opa       (opa),
        .opb       (opb),
        .path      (a_path),
        .res_sign  (a_sign),
        .eff_sub   (a_sub),
        .big_exp   (a_exp),
        .big_sig   (a_sig),
        .small_al  (a_small),
        .pass_word (a_pass)
    );

    // Stage-1 register: capture aligned operands when a pair arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_path  <= PATH_ZERO;
            s1_sign  <= 1'b0;
            s1_sub   <= 1'b0;
            s1_exp   <= '0;
            s1_sig   <= '0;
            s1_small <= '0;
            s1_pass  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_path  <= a_path;
                s1_sign  <= a_sign;
                s1_sub   <= a_sub;
                s1_exp   <= a_exp;
                s1_sig   <= a_sig;
                s1_small <= a_small;
                s1_pass  <= a_pass;
            end
        end
    end

    hub_fp_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
        .path      (s1_path),
        .res_sign  (s1_sign),
        .eff_sub   (s1_sub),
        .big_exp   (s1_exp),
        .big_sig   (s1_sig),
        .small_al  (s1_small),
        .pass_word (s1_pass),
        .word      (n_word)
    );

    // Output register: publish the packed result with its valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) result <= n_word;
        end
    end
endmodule

// File: rtl/hub_fp_adder_chk.sv
// Checker for hub_fp_adder, attached by bind. Observes only the ports.
// A saturating edge counter keeps $past lookups inside the post-reset window.
module hub_fp_adder_chk #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 op_sub,
    input logic [EXP_W+MAN_W:0] opa,
    input logic [EXP_W+MAN_W:0] opb,
    input logic                 out_valid,
    input logic [EXP_W+MAN_W:0] result
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic [1:0] cyc;

    // Count edges since reset release, saturating at 3
    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R6
    zero_canonical_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[W-2 -: EXP_W] == '0) |-> (result == '0));

    // R5
    pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && out_valid &&
         $past(in_valid && opb[W-2 -: EXP_W] == '0 && opa[W-2 -: EXP_W] != '0, 2))
        |-> (result == $past(opa, 2)));

    // R5
    pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && out_valid &&
         $past(in_valid && !op_sub && opa[W-2 -: EXP_W] == '0 && opb[W-2 -: EXP_W] != '0, 2))
        |-> (result == $past(opb, 2)));

    // R3
    same_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2 && out_valid &&
         $past(in_valid && opa[W-2 -: EXP_W] != '0 && opb[W-2 -: EXP_W] != '0 &&
               (opa[W-1] == (opb[W-1] ^ op_sub)), 2))
        |-> (result[W-1] == $past(opa[W-1], 2)));
endmodule

bind hub_fp_adder hub_fp_adder_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_sub    (op_sub),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/hub_fp_adder_test.sv
`timescale 1ns/1ps
// Bench: exact-value reference model on wide integers, compared every clock.
module hub_fp_adder_test;
    localparam int E = 5;
    localparam int M = 10;
    localparam int W = 1 + E + M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         out_valid;
    logic [W-1:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic         e1_v = 1'b0, e2_v = 1'b0;
    logic [W-1:0] e1_r = '0, e2_r = '0;
    string        e1_t = "", e2_t = "";

    hub_fp_adder #(.EXP_W(E), .MAN_W(M)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .opa(opa), .opb(opb), .out_valid(out_valid), .result(result)
    );

    always #10 clk = ~clk;

    function automatic longint value_of(input logic [W-1:0] x);
        longint sig, v;
        if (x[W-2 -: E] == '0) return 0;
        sig = (longint'(1) << (M + 1)) | (longint'(x[M-1:0]) << 1) | 1;
        v = sig << (int'(x[W-2 -: E]) - 1);
        return x[W-1] ? -v : v;
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] a, b, input logic sub);
        longint s, vb;
        longint unsigned mag;
        int t, er;
        logic [M-1:0] mt;
        vb = value_of(b);
        if (sub) vb = -vb;
        s = value_of(a) + vb;
        if (s == 0) return '0;
        mag = (s < 0) ? longint'(-s) : longint'(s);
        t = 0;
        for (int i = 0; i < 63; i++) if (mag[i]) t = i;
        er = t - M;
        if (er <= 0) return '0;
        if (er > (1 << E) - 1) return {s < 0, {E{1'b1}}, {M{1'b1}}};
        mt = M'(mag >> (t - M));
        return {s < 0, E'(er), mt};
    endfunction

    function automatic logic [W-1:0] mk(input logic s, input int e, input int m);
        return {s, E'(e), M'(m)};
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== e2_v) begin
            errors++;
            $display("FAIL R2: out_valid=%b expected %b", out_valid, e2_v);
        end
        if (e2_v) begin
            checks++;
            if (result !== e2_r) begin
                errors++;
                $display("FAIL %s: result=%h expected %h", e2_t, result, e2_r);
            end
        end
    endtask

    task automatic step(input logic v, input logic s, input logic [W-1:0] a, b, input string tag);
        @(negedge clk);
        check_out();
        e2_v = e1_v; e2_r = e1_r; e2_t = e1_t;
        in_valid = v; op_sub = s; opa = a; opb = b;
        e1_v = v; e1_r = model(a, b, s); e1_t = tag;
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset clears outputs
        checks++;
        if (out_valid !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R10: out_valid=%b result=%h expected 0 0", out_valid, result);
        end
        rst_n = 1'b1;

        // R1: plain additions
        step(1, 0, mk(0, 15, 0),     mk(0, 15, 0),     "R1");
        step(1, 0, mk(0, 15, 1023),  mk(0, 14, 513),   "R1");
        step(1, 0, mk(1, 20, 77),    mk(1, 18, 900),   "R1");
        // R4: subtraction, including near-unity cancellation
        step(1, 1, mk(0, 16, 0),     mk(0, 15, 1023),  "R4");
        step(1, 1, mk(0, 10, 300),   mk(1, 9, 12),     "R4");
        step(1, 1, mk(0, 12, 5),     mk(0, 12, 4),     "R4");
        // R3: sign follows the larger magnitude
        step(1, 0, mk(0, 8, 3),      mk(1, 9, 3),      "R3");
        step(1, 1, mk(1, 8, 100),    mk(1, 8, 200),    "R3");
        // R5: zero operands with junk sign/mantissa
        step(1, 0, mk(0, 17, 321),   mk(1, 0, 1023),   "R5");
        step(1, 1, mk(1, 0, 555),    mk(0, 17, 321),   "R5");
        step(1, 1, mk(1, 0, 7),      mk(1, 0, 9),      "R5");
        // R6: exact cancellation
        step(1, 1, mk(0, 22, 444),   mk(0, 22, 444),   "R6");
        step(1, 0, mk(1, 3, 1),      mk(0, 3, 1),      "R6");
        // R7: overflow saturates
        step(1, 0, mk(0, 31, 1000),  mk(0, 31, 900),   "R7");
        step(1, 1, mk(1, 31, 1023),  mk(0, 30, 1023),  "R7");
        // R8: underflow flushes to zero
        step(1, 1, mk(0, 1, 1),      mk(0, 1, 0),      "R8");
        // R9: far and just-near exponent differences
        step(1, 0, mk(0, 20, 0),     mk(0, 8, 1023),   "R9");
        step(1, 1, mk(0, 20, 0),     mk(0, 8, 1023),   "R9");
        step(1, 1, mk(0, 20, 0),     mk(0, 9, 1023),   "R9");
        step(1, 0, mk(1, 4, 17),     mk(0, 30, 2),     "R9");
        // R2: bubbles between operations
        step(0, 0, mk(0, 5, 5),      mk(0, 5, 5),      "R2");
        step(1, 0, mk(0, 6, 6),      mk(0, 6, 7),      "R2");
        step(0, 1, mk(0, 9, 9),      mk(0, 9, 9),      "R2");

        // R1: random stream, some pairs close in value to stress cancellation
        for (int k = 0; k < 600; k++) begin
            logic [W-1:0] a, b;
            a = W'($urandom);
            b = (k % 3 == 0) ? (a ^ W'($urandom_range(0, 15))) : W'($urandom);
            step(($urandom_range(0, 4) != 0), logic'($urandom_range(0, 1)), a, b, "R1");
        end

        step(0, 0, '0, '0, "R2");
        step(0, 0, '0, '0, "R2");
        step(0, 0, '0, '0, "R2");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule